// File: doc/BRIEF.md
# Exception Vector Dispatch Unit

This unit turns exceptional events into a change of program flow. It holds a 256-entry table of handler start addresses, written by system software through a single write port during initialization. Every cycle it looks at six event sources: a built-in divide-by-zero detector, software trap instructions carrying an immediate vector, external interrupt lines, a free-running periodic timer, fault flags and abort flags. It picks one event, uses its vector number directly as the table index, and sends the fetch unit a one-cycle redirect carrying the handler address.

At the same moment it records a return address chosen by the event's class. For a fault it records the address of the offending instruction, so that instruction runs again. For a trap or an interrupt it records the address of the following instruction. For an abort it records no usable return point and pulses a terminate output instead. While a handler runs, interrupts and timer ticks are held back. A return-from-exception pulse sends fetch back to the recorded address and lifts the hold.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, redirect_valid, terminate, handler_active and epc_valid are all 0.
- R2: A cycle with tbl_we high stores tbl_data in entry tbl_idx. Any event with vector k taken later redirects to the last value stored in entry k.
- R3: div_valid with div_divisor equal to zero raises a fault with vector 0. A nonzero divisor raises no event.
- R4: trap_valid raises a trap whose vector is trap_code (0x80 is the system call, vector 128). epc becomes next_pc.
- R5: fault_valid raises a fault with vector fault_vec. epc becomes cur_pc and epc_valid becomes 1.
- R6: abort_valid raises an abort with vector abort_vec. redirect_valid and terminate pulse together, and epc_valid becomes 0.
- R7: A rising edge on irq[i] is brought through two synchronizer flops and then pends vector IRQ_BASE+i. When several lines are pending, the lowest index is taken first. epc becomes next_pc.
- R8: Every TMR_PERIOD clock cycles the timer pends vector TMR_VEC (default 200). epc becomes next_pc. Two timer events taken without masking are exactly TMR_PERIOD cycles apart.
- R9: Priority is abort, then fault (the divide-by-zero fault goes ahead of fault_vec), then trap, then interrupt, then timer. Interrupts and timer ticks that lose stay pending. Synchronous requests that lose in the same cycle are dropped.
- R10: While handler_active is 1, pending interrupts and timer ticks are not taken. Aborts, faults and traps are still taken.
- R11: An eret pulse clears handler_active. If epc_valid is 1, the next cycle also redirects to epc. If epc_valid is 0, no redirect follows. An event in the same cycle as eret is served instead of the eret.
- R12: An event taken at clock edge k shows up after edge k as redirect_valid high for exactly one cycle. At the same time redirect_pc holds the table entry, cause holds the vector, and handler_active becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Handler table write strobe |
| tbl_idx | input | VEC_W | Table entry to write |
| tbl_data | input | ADDR_W | Handler address to store |
| cur_pc | input | ADDR_W | Address of the instruction in execution |
| next_pc | input | ADDR_W | Address of the instruction that follows |
| div_valid | input | 1 | A divide executes this cycle |
| div_divisor | input | DATA_W | Divisor of that divide |
| trap_valid | input | 1 | A trap instruction executes this cycle |
| trap_code | input | VEC_W | Immediate vector of the trap |
| fault_valid | input | 1 | Recoverable fault flag |
| fault_vec | input | VEC_W | Vector of the fault |
| abort_valid | input | 1 | Unrecoverable error flag |
| abort_vec | input | VEC_W | Vector of the abort |
| irq | input | IRQ_N | Asynchronous external interrupt lines |
| eret | input | 1 | Return from exception pulse |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | ADDR_W | Address fetch continues from |
| cause | output | VEC_W | Vector of the last event taken |
| epc | output | ADDR_W | Saved return address |
| epc_valid | output | 1 | epc holds a resumable return point |
| terminate | output | 1 | Abort taken; the running program must end |
| handler_active | output | 1 | A handler runs; interrupts and timer are held |

## Verification
The hardest case to reach is an interrupt that becomes pending while a handler already runs. The interrupt must stay pending across the masked window, and it must win over a timer tick that is also pending at the moment eret lifts the mask. The bench enters a handler with a trap, raises two interrupt lines and holds them for many cycles while it watches for any redirect. It then pulses eret twice. After each eret it expects the return redirect, followed on the very next cycle by the lowest pending line and then by the next one. The timer period is measured between two unmasked ticks that are separated only by an eret.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [2:0] {
        EC_NONE  = 3'd0,
        EC_ABORT = 3'd1,
        EC_FAULT = 3'd2,
        EC_TRAP  = 3'd3,
        EC_IRQ   = 3'd4,
        EC_TIMER = 3'd5
    } exc_class_e;
endpackage

// File: rtl/exc_vec_table.sv
module exc_vec_table #(
    parameter int VEC_N  = 256,
    parameter int ADDR_W = 32,
    localparam int VEC_W = $clog2(VEC_N)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [VEC_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [VEC_W-1:0]  ridx,
    output logic [ADDR_W-1:0] rdata
);
    logic [ADDR_W-1:0] mem_q [VEC_N];

    always_ff @(posedge clk) begin
        if (we) mem_q[widx] <= wdata;
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
    parameter int IRQ_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] irq_in,
    input  logic [IRQ_N-1:0] clr,
    output logic [IRQ_N-1:0] pend
);
    logic [IRQ_N-1:0] meta_q, sync_q, last_q, pend_q, pend_d;

    for (genvar g = 0; g < IRQ_N; g++) begin : g_line
        always_comb begin
            pend_d[g] = (pend_q[g] & ~clr[g]) | (sync_q[g] & ~last_q[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
            pend_q <= '0;
        end else begin
            meta_q <= irq_in;
            sync_q <= meta_q;
            last_q <= sync_q;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/exc_timer.sv
module exc_timer #(
    parameter int PERIOD = 1250000,
    localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic pend
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pend_q, pend_d;
    logic             wrap;

    always_comb begin
        wrap   = (cnt_q == CNT_W'(PERIOD - 1));
        cnt_d  = wrap ? '0 : cnt_q + 1'b1;
        pend_d = (pend_q & ~clr) | wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int IRQ_N    = 4,
    parameter int VEC_W    = 8,
    parameter int IRQ_BASE = 32,
    parameter int TMR_VEC  = 200,
    localparam int IDX_W   = (IRQ_N > 1) ? $clog2(IRQ_N) : 1
) (
    input  logic             abort_valid,
    input  logic [VEC_W-1:0] abort_vec,
    input  logic             fault_valid,
    input  logic [VEC_W-1:0] fault_vec,
    input  logic             trap_valid,
    input  logic [VEC_W-1:0] trap_code,
    input  logic [IRQ_N-1:0] irq_pend,
    input  logic             tmr_pend,
    input  logic             mask,
    output logic             take,
    output exc_class_e       cls,
    output logic [VEC_W-1:0] vec,
    output logic [IRQ_N-1:0] irq_clr,
    output logic             tmr_clr
);
    logic [IDX_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = IRQ_N - 1; i >= 0; i--) begin
            if (irq_pend[i]) sel = IDX_W'(i);
        end
    end

    always_comb begin
        take    = 1'b0;
        cls     = EC_NONE;
        vec     = '0;
        irq_clr = '0;
        tmr_clr = 1'b0;
        if (abort_valid) begin
            take = 1'b1; cls = EC_ABORT; vec = abort_vec;
        end else if (fault_valid) begin
            take = 1'b1; cls = EC_FAULT; vec = fault_vec;
        end else if (trap_valid) begin
            take = 1'b1; cls = EC_TRAP; vec = trap_code;
        end else if (!mask && (|irq_pend)) begin
            take = 1'b1; cls = EC_IRQ;
            vec  = VEC_W'(IRQ_BASE) + VEC_W'(sel);
            irq_clr[sel] = 1'b1;
        end else if (!mask && tmr_pend) begin
            take = 1'b1; cls = EC_TIMER; vec = VEC_W'(TMR_VEC);
            tmr_clr = 1'b1;
        end
    end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int VEC_N      = 256,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int IRQ_N      = 4,
    parameter int IRQ_BASE   = 32,
    parameter int TMR_VEC    = 200,
    parameter int TMR_PERIOD = 1250000,
    localparam int VEC_W     = $clog2(VEC_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [VEC_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_data,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic              div_valid,
    input  logic [DATA_W-1:0] div_divisor,
    input  logic              trap_valid,
    input  logic [VEC_W-1:0]  trap_code,
    input  logic              fault_valid,
    input  logic [VEC_W-1:0]  fault_vec,
    input  logic              abort_valid,
    input  logic [VEC_W-1:0]  abort_vec,
    input  logic [IRQ_N-1:0]  irq,
    input  logic              eret,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [VEC_W-1:0]  cause,
    output logic [ADDR_W-1:0] epc,
    output logic              epc_valid,
    output logic              terminate,
    output logic              handler_active
);
    typedef struct packed {
        logic              rv;
        logic [ADDR_W-1:0] rpc;
        logic [VEC_W-1:0]  cause;
        logic [ADDR_W-1:0] epc;
        logic              epc_ok;
        logic              term;
        logic              act;
    } state_t;

    state_t s_q, s_d;

    logic              div_zero;
    logic              any_fault;
    logic [VEC_W-1:0]  any_fault_vec;
    logic [IRQ_N-1:0]  irq_pend, irq_clr;
    logic              tmr_pend, tmr_clr;
    logic              take;
    exc_class_e        arb_cls;
    logic [VEC_W-1:0]  arb_vec;
    logic [ADDR_W-1:0] hnd_addr;

    assign div_zero      = div_valid && (div_divisor == '0);
    assign any_fault     = div_zero || fault_valid;
    assign any_fault_vec = div_zero ? '0 : fault_vec;

    exc_vec_table #(.VEC_N(VEC_N), .ADDR_W(ADDR_W)) u_table (
        .clk  (clk),
        .we   (tbl_we),
        .widx (tbl_idx),
        .wdata(tbl_data),
        .ridx (arb_vec),
        .rdata(hnd_addr)
    );

    exc_irq_sync #(.IRQ_N(IRQ_N)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .irq_in(irq),
        .clr   (irq_clr),
        .pend  (irq_pend)
    );

    exc_timer #(.PERIOD(TMR_PERIOD)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .pend (tmr_pend)
    );

    exc_arbiter #(
        .IRQ_N(IRQ_N), .VEC_W(VEC_W), .IRQ_BASE(IRQ_BASE), .TMR_VEC(TMR_VEC)
    ) u_arb (
        .abort_valid(abort_valid),
        .abort_vec  (abort_vec),
        .fault_valid(any_fault),
        .fault_vec  (any_fault_vec),
        .trap_valid (trap_valid),
        .trap_code  (trap_code),
        .irq_pend   (irq_pend),
        .tmr_pend   (tmr_pend),
        .mask       (s_q.act),
        .take       (take),
        .cls        (arb_cls),
        .vec        (arb_vec),
        .irq_clr    (irq_clr),
        .tmr_clr    (tmr_clr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.rv   = 1'b0;
        s_d.term = 1'b0;
        if (take) begin
            s_d.rv    = 1'b1;
            s_d.rpc   = hnd_addr;
            s_d.cause = arb_vec;
            s_d.act   = 1'b1;
            case (arb_cls)
                EC_ABORT: begin
                    s_d.epc_ok = 1'b0;
                    s_d.term   = 1'b1;
                end
                EC_FAULT: begin
                    s_d.epc    = cur_pc;
                    s_d.epc_ok = 1'b1;
                end
                default: begin
                    s_d.epc    = next_pc;
                    s_d.epc_ok = 1'b1;
                end
            endcase
        end else if (eret) begin
            s_d.act = 1'b0;
            if (s_q.epc_ok) begin
                s_d.rv  = 1'b1;
                s_d.rpc = s_q.epc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign redirect_valid = s_q.rv;
    assign redirect_pc    = s_q.rpc;
    assign cause          = s_q.cause;
    assign epc            = s_q.epc;
    assign epc_valid      = s_q.epc_ok;
    assign terminate      = s_q.term;
    assign handler_active = s_q.act;
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eret,
    input logic [ADDR_W-1:0] cur_pc,
    input logic [ADDR_W-1:0] next_pc,
    input logic              take,
    input exc_class_e        cls,
    input logic              handler_active,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic              terminate,
    input logic [ADDR_W-1:0] epc,
    input logic              epc_valid
);
    a_r6_abort_no_return: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && terminate) |-> !epc_valid);

    a_r12_term_with_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        terminate |-> redirect_valid);

    a_r5_fault_saves_cur: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls == EC_FAULT) |=> (epc == $past(cur_pc)) && epc_valid);

    a_r4_resume_next: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cls == EC_TRAP || cls == EC_IRQ || cls == EC_TIMER))
        |=> (epc == $past(next_pc)) && epc_valid);

    a_r10_async_masked: assert property (@(posedge clk) disable iff (!rst_n)
        handler_active |-> !(take && (cls == EC_IRQ || cls == EC_TIMER)));

    a_r11_eret_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !take && epc_valid)
        |=> redirect_valid && (redirect_pc == $past(epc)) && !handler_active);

    a_r12_take_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redirect_valid && handler_active);
endmodule

bind exc_dispatch exc_dispatch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .eret          (eret),
    .cur_pc        (cur_pc),
    .next_pc       (next_pc),
    .take          (take),
    .cls           (arb_cls),
    .handler_active(handler_active),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .terminate     (terminate),
    .epc           (epc),
    .epc_valid     (epc_valid)
);

// File: tb/tb_exc_dispatch.sv
`timescale 1ns/1ps
module tb_exc_dispatch;
    localparam int PER   = 300;
    localparam int IBASE = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [7:0]  tbl_idx = '0;
    logic [31:0] tbl_data = '0;
    logic [31:0] cur_pc = '0, next_pc = '0;
    logic        div_valid = 1'b0;
    logic [31:0] div_divisor = '0;
    logic        trap_valid = 1'b0;
    logic [7:0]  trap_code = '0;
    logic        fault_valid = 1'b0;
    logic [7:0]  fault_vec = '0;
    logic        abort_valid = 1'b0;
    logic [7:0]  abort_vec = '0;
    logic [3:0]  irq = '0;
    logic        eret = 1'b0;
    logic        redirect_valid, epc_valid, terminate, handler_active;
    logic [31:0] redirect_pc, epc;
    logic [7:0]  cause;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    exc_dispatch #(.IRQ_N(4), .IRQ_BASE(IBASE), .TMR_VEC(200), .TMR_PERIOD(PER)) dut (.*);

    function automatic logic [31:0] h(input int k);
        return 32'h4000_0000 + 32'(k) * 32'h100;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int k, input logic [31:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 8'(k); tbl_data = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic pulse_eret();
        @(negedge clk); eret = 1'b1;
        @(negedge clk); eret = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "redirect_valid", 32'(redirect_valid), 0);
        chk("R1", "terminate", 32'(terminate), 0);
        chk("R1", "handler_active", 32'(handler_active), 0);
        chk("R1", "epc_valid", 32'(epc_valid), 0);
    endtask

    task automatic t_program();
        int ks[11] = '{0, 7, 13, 14, 18, 128, 200, 32, 33, 34, 35};
        foreach (ks[i]) wr(ks[i], h(ks[i]));
    endtask

    task automatic t_trap();
        cur_pc = 32'h0800_C040; next_pc = 32'h0800_C050;
        @(negedge clk); trap_valid = 1'b1; trap_code = 8'h80;
        @(negedge clk); trap_valid = 1'b0;
        chk("R4", "redirect_valid", 32'(redirect_valid), 1);
        chk("R4", "redirect_pc", redirect_pc, h(128));
        chk("R4", "cause", 32'(cause), 128);
        chk("R4", "epc", epc, 32'h0800_C050);
        chk("R12", "handler_active", 32'(handler_active), 1);
        @(negedge clk);
        chk("R12", "redirect one cycle", 32'(redirect_valid), 0);
    endtask

    task automatic t_div();
        cur_pc = 32'h0800_D000; next_pc = 32'h0800_D004;
        @(negedge clk); div_valid = 1'b1; div_divisor = 32'd5;
        @(negedge clk); div_valid = 1'b0;
        chk("R3", "nonzero divisor no redirect", 32'(redirect_valid), 0);
        @(negedge clk); div_valid = 1'b1; div_divisor = 32'd0;
        @(negedge clk); div_valid = 1'b0;
        chk("R3", "div0 redirect_pc", redirect_pc, h(0));
        chk("R3", "div0 cause", 32'(cause), 0);
        chk("R3", "div0 epc", epc, 32'h0800_D000);
    endtask

    task automatic t_fault();
        cur_pc = 32'h0800_E010; next_pc = 32'h0800_E014;
        @(negedge clk); fault_valid = 1'b1; fault_vec = 8'd14;
        @(negedge clk); fault_valid = 1'b0;
        chk("R5", "redirect_pc", redirect_pc, h(14));
        chk("R5", "epc", epc, 32'h0800_E010);
        chk("R5", "epc_valid", 32'(epc_valid), 1);
    endtask

    task automatic t_irq_mask();
        bit seen = 1'b0;
        cur_pc = 32'h0000_1000; next_pc = 32'h0000_1004;
        @(negedge clk); irq = 4'b1010;
        repeat (12) begin
            @(negedge clk);
            if (redirect_valid) seen = 1'b1;
        end
        chk("R10", "irq held while active", 32'(seen), 0);
        @(negedge clk); trap_valid = 1'b1; trap_code = 8'd7;
        @(negedge clk); trap_valid = 1'b0;
        chk("R4", "trap 7 cause", 32'(cause), 7);
        next_pc = 32'h0000_2004;
        pulse_eret();
        chk("R11", "eret redirect_pc", redirect_pc, 32'h0000_1004);
        chk("R11", "eret clears active", 32'(handler_active), 0);
        @(negedge clk);
        chk("R7", "lowest line first", 32'(cause), IBASE + 1);
        chk("R7", "irq redirect_pc", redirect_pc, h(IBASE + 1));
        chk("R7", "irq epc", epc, 32'h0000_2004);
        @(negedge clk);
        chk("R10", "line 3 waits", 32'(redirect_valid), 0);
        irq = 4'b0000;
        pulse_eret();
        chk("R11", "second eret", redirect_pc, 32'h0000_2004);
        @(negedge clk);
        chk("R9", "pending line kept", 32'(cause), IBASE + 3);
    endtask

    task automatic t_priority();
        cur_pc = 32'h0000_3000; next_pc = 32'h0000_3004;
        @(negedge clk);
        abort_valid = 1'b1; abort_vec = 8'd18;
        fault_valid = 1'b1; fault_vec = 8'd13;
        trap_valid = 1'b1; trap_code = 8'h80;
        @(negedge clk);
        abort_valid = 1'b0; fault_valid = 1'b0; trap_valid = 1'b0;
        chk("R9", "abort wins", 32'(cause), 18);
        chk("R6", "terminate", 32'(terminate), 1);
        chk("R6", "epc_valid cleared", 32'(epc_valid), 0);
        chk("R6", "abort redirect_pc", redirect_pc, h(18));
        @(negedge clk);
        chk("R6", "terminate one cycle", 32'(terminate), 0);
        @(negedge clk);
        fault_valid = 1'b1; fault_vec = 8'd13;
        trap_valid = 1'b1; trap_code = 8'h80;
        div_valid = 1'b1; div_divisor = 32'd0;
        @(negedge clk);
        fault_valid = 1'b0; trap_valid = 1'b0; div_valid = 1'b0;
        chk("R9", "div0 over fault and trap", 32'(cause), 0);
        chk("R9", "fault epc", epc, 32'h0000_3000);
        @(negedge clk);
        chk("R9", "losing trap dropped", 32'(redirect_valid), 0);
    endtask

    task automatic t_abort_eret();
        @(negedge clk); abort_valid = 1'b1; abort_vec = 8'd18;
        @(negedge clk); abort_valid = 1'b0;
        pulse_eret();
        chk("R11", "no return after abort", 32'(redirect_valid), 0);
        chk("R11", "active cleared", 32'(handler_active), 0);
    endtask

    task automatic t_timer();
        int t0 = 0, t1 = 0;
        bit got = 1'b0;
        next_pc = 32'h0000_5008;
        for (int i = 0; i < 2 * PER + 10 && !got; i++) begin
            @(negedge clk);
            if (redirect_valid && redirect_pc == h(200)) begin got = 1'b1; t0 = cyc; end
        end
        chk("R8", "timer event seen", 32'(got), 1);
        chk("R8", "timer cause", 32'(cause), 200);
        chk("R8", "timer epc", epc, 32'h0000_5008);
        pulse_eret();
        got = 1'b0;
        for (int i = 0; i < 2 * PER + 10 && !got; i++) begin
            @(negedge clk);
            if (redirect_valid && redirect_pc == h(200)) begin got = 1'b1; t1 = cyc; end
        end
        chk("R8", "timer interval", 32'(t1 - t0), PER);
    endtask

    task automatic t_rewrite();
        wr(13, 32'hABCD_0000);
        cur_pc = 32'h0000_6000;
        @(negedge clk); fault_valid = 1'b1; fault_vec = 8'd13;
        @(negedge clk); fault_valid = 1'b0;
        chk("R2", "rewritten entry used", redirect_pc, 32'hABCD_0000);
        chk("R2", "cause", 32'(cause), 13);
    endtask

    initial begin
        t_reset();
        t_program();
        t_trap();
        t_div();
        t_fault();
        t_irq_mask();
        t_priority();
        t_abort_eret();
        t_timer();
        t_rewrite();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule